// File: doc/BRIEF.md
# Select-Gated SPI Slave Byte Port

This block is the receiving end of an SPI link that moves one byte at a time. The serial clock always comes from the external master. The slave never drives it. A fast local system clock oversamples the serial clock, the select line and the data input through a two-stage synchronizer. It then acts on the edges of the synchronized serial clock. The system clock has to run at least four times faster than the serial clock.

Local logic loads the next outgoing byte with a write strobe. It collects each finished incoming byte from a receive buffer and frees that buffer with a read strobe. When the eighth bit has been captured, the block raises a single-cycle completion pulse and marks the buffer full. The output driver is modelled as a data pin plus an active-high output enable. When the enable is low, the pad is released.

A four-bit mode field picks between two operations:
- **Select-gated** (`4'b0100`): transfers run only while `ss_n` is low, and raising `ss_n` aborts the byte in progress.
- **Free-running** (`4'b0101`): `ss_n` is ignored.

Any other mode value is illegal and holds the port idle. So is free-running together with `cke=1`.

The control is a four-state machine:
- **OFF**: disabled, illegal or deselected.
- **WAIT**: enabled, waiting for the serial clock to settle at its idle level.
- **ARMED**: no bit of the current byte taken yet.
- **SHIFT**: one to seven bits taken.

Its transitions are:
- OFF→WAIT when the port becomes enabled and selected.
- WAIT→ARMED when the synchronized clock equals `cpol`.
- ARMED→SHIFT on the first sample edge.
- SHIFT→SHIFT on samples two to seven.
- SHIFT→ARMED on the eighth sample.
- Any state→OFF as soon as the port stops being enabled, legal and selected.

Top module: `spi_sel_slave`

## Requirements
- R1: After reset, `sdo_oe`, `rx_valid`, `byte_done`, `rx_ovf` and `wr_col` are 0, and `rx_data` is 0.
- R2: Bits leave most significant first. Bit 7 of the transmit buffer is on `sdo` from the moment the port is idle or armed. Each shift edge taken after the first sample of the byte presents the next lower bit.
- R3: Incoming bits are captured most significant first on sample edges. After the eighth sample, `rx_data` holds the byte, `rx_valid` is 1, and `byte_done` pulses high for exactly one cycle.
- R4: The leading edge is the one that leaves the idle level; the trailing edge returns to it. With `cke=1` the shift edge is the trailing edge, and with `cke=0` it is the leading edge. With `smp=0` the sample edge is the edge opposite the shift edge, and with `smp=1` sampling moves onto the shift edge itself.
- R5: `cpol` gives the idle level of `sck`. If the port is enabled while `sck` is away from that level, no edge counts until `sck` has returned to idle.
- R6: In mode `4'b0100`, bits are taken only while `ss_n` is low. Raising `ss_n`, even mid-byte, clears the bit count, so the next full byte after reselection is received intact.
- R7: `sdo_oe` is 1 only when the port is enabled with a legal configuration, `tx_disable` is 0, and (in mode `4'b0100`) the raw `ss_n` is low. It drops in the same cycle that `ss_n` rises.
- R8: In mode `4'b0101` with `cke=0`, `ss_n` has no effect: the output is driven and bytes are received with `ss_n` high.
- R9: A mode other than `4'b0100` or `4'b0101`, or mode `4'b0101` with `cke=1`, keeps the port idle: `sdo_oe` stays 0 and clocking produces no byte.
- R10: With `en` low, the bit count is cleared and `rx_ovf` and `wr_col` read 0.
- R11: If a byte completes while `rx_valid` is still 1, `rx_ovf` becomes 1 and `rx_data` keeps the older byte.
- R12: A `tx_wr` while a byte is in progress (state SHIFT) sets `wr_col` and leaves the transmit buffer unchanged. A `tx_wr` at any other time replaces it.
- R13: A one-cycle `rx_rd` clears `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable; low clears the bit count and flags |
| mode | input | 4 | Operating mode: 4'b0100 select-gated, 4'b0101 free-running |
| cpol | input | 1 | Idle level of the serial clock |
| cke | input | 1 | Shift-edge select (1: trailing edge) |
| smp | input | 1 | Sample-phase select (1: sample on shift edge) |
| tx_disable | input | 1 | Keep the data output released, receive only |
| sck | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (valid when sdo_oe is 1) |
| sdo_oe | output | 1 | Output enable for the sdo pad |
| tx_wr | input | 1 | Strobe loading tx_data into the transmit buffer |
| tx_data | input | 8 | Next byte to transmit |
| rx_rd | input | 1 | Strobe marking the receive buffer as read |
| rx_data | output | 8 | Last accepted received byte |
| rx_valid | output | 1 | Receive buffer holds an unread byte |
| byte_done | output | 1 | One-cycle pulse when a byte completes |
| rx_ovf | output | 1 | A byte completed while the buffer was unread |
| wr_col | output | 1 | Transmit buffer written while a byte was in progress |

## Verification
The bench goes after five corner cases:
- **Deselect in mid-byte, then a full byte.** A design that kept its partial count would finish that byte early, with the bits shifted out of place.
- **Enabling while the clock sits at its active level.** A design that counted the return-to-idle edge as a sample would misalign every later byte.
- **Overflow.** The second byte must leave the first one in the buffer; a careless design would overwrite it.
- **Collision write.** The byte sent next must still be the old one, which a design that accepted the write would break.
- **Illegal configurations and receive-only mode.** A leaky enable or gating term would drive the pad or produce bytes when it should not.

All four combinations of shift edge and sample phase, and both clock polarities, are run through a reference model that is compared on every settled clock.

// File: rtl/spi_sel_pkg.sv
`timescale 1ns/1ps
package spi_sel_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_WAIT,
        ST_ARMED,
        ST_SHIFT
    } link_st_t;

    localparam logic [3:0] MODE_SEL  = 4'b0100;
    localparam logic [3:0] MODE_FREE = 4'b0101;

endpackage

// File: rtl/spi_sync.sv
`timescale 1ns/1ps
module spi_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d_in;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign d_out = chain[STAGES-1];

endmodule

// File: rtl/spi_link_fsm.sv
`timescale 1ns/1ps
module spi_link_fsm
    import spi_sel_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     go,
    input  logic     cpol,
    input  logic     cke,
    input  logic     smp,
    input  logic     sck_s,
    output link_st_t state,
    output logic     sample_ev,
    output logic     shift_ev,
    output logic     done_ev
);

    localparam int              CNT_W = $clog2(BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

    link_st_t         st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             sck_q;
    logic             lead_e, trail_e, shift_raw, samp_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    // outputs: edge classification and qualified events
    always_comb begin
        lead_e    = (sck_q == cpol) && (sck_s != cpol);
        trail_e   = (sck_q != cpol) && (sck_s == cpol);
        shift_raw = cke ? trail_e : lead_e;
        samp_raw  = smp ? shift_raw : (cke ? lead_e : trail_e);
        sample_ev = go && samp_raw && ((state == ST_ARMED) || (state == ST_SHIFT));
        shift_ev  = go && shift_raw && (state == ST_SHIFT);
        done_ev   = sample_ev && (state == ST_SHIFT) && (cnt == LAST);
    end

    always_comb begin
        st_n  = state;
        cnt_n = cnt;
        if (!go) begin
            st_n  = ST_OFF;
            cnt_n = '0;
        end else begin
            unique case (state)
                ST_OFF:   st_n = ST_WAIT;
                ST_WAIT:  if (sck_s == cpol) st_n = ST_ARMED;
                ST_ARMED: if (sample_ev) begin
                              st_n  = ST_SHIFT;
                              cnt_n = CNT_W'(1);
                          end
                ST_SHIFT: if (sample_ev) begin
                              if (cnt == LAST) begin
                                  st_n  = ST_ARMED;
                                  cnt_n = '0;
                              end else begin
                                  cnt_n = cnt + 1'b1;
                              end
                          end
                default:  st_n = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            state <= st_n;
            cnt   <= cnt_n;
        end
    end

    assert_stop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (state == ST_OFF && cnt == '0));

    assert_wait_until_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && sck_s != cpol && go) |=> (state != ST_SHIFT));

endmodule

// File: rtl/spi_byte_path.sv
`timescale 1ns/1ps
module spi_byte_path #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            busy,
    input  logic            sample_ev,
    input  logic            shift_ev,
    input  logic            done_ev,
    input  logic            sdi_s,
    input  logic            tx_wr,
    input  logic [BITS-1:0] tx_data,
    input  logic            rx_rd,
    output logic            tx_bit,
    output logic [BITS-1:0] rx_data,
    output logic            rx_valid,
    output logic            byte_done,
    output logic            rx_ovf,
    output logic            wr_col
);

    logic [BITS-1:0] tx_buf, tx_sr, rx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_buf <= '0;
            tx_sr  <= '0;
        end else begin
            if (tx_wr && !busy) tx_buf <= tx_data;
            if (shift_ev)       tx_sr  <= {tx_sr[BITS-2:0], 1'b0};
            else if (!busy)     tx_sr  <= tx_buf;
        end
    end

    assign tx_bit = tx_sr[BITS-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr     <= '0;
            rx_data   <= '0;
            rx_valid  <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= done_ev;
            if (sample_ev) rx_sr <= {rx_sr[BITS-2:0], sdi_s};
            if (done_ev) begin
                if (!rx_valid) rx_data <= {rx_sr[BITS-2:0], sdi_s};
                rx_valid <= 1'b1;
            end else if (rx_rd) begin
                rx_valid <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_ovf <= 1'b0;
            wr_col <= 1'b0;
        end else if (!en) begin
            rx_ovf <= 1'b0;
            wr_col <= 1'b0;
        end else begin
            if (done_ev && rx_valid) rx_ovf <= 1'b1;
            if (tx_wr && busy)       wr_col <= 1'b1;
        end
    end

    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);

    assert_valid_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> rx_valid);

    assert_ovf_keeps_old_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ev && rx_valid) |=> (rx_ovf && $stable(rx_data)));

    assert_en_clears_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!rx_ovf && !wr_col));

    assert_col_keeps_buf_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && busy) |=> $stable(tx_buf));

endmodule

// File: rtl/spi_sel_slave.sv
`timescale 1ns/1ps
module spi_sel_slave
    import spi_sel_pkg::*;
#(
    parameter int BITS     = 8,
    parameter int SYNC_LEN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [3:0]      mode,
    input  logic            cpol,
    input  logic            cke,
    input  logic            smp,
    input  logic            tx_disable,
    input  logic            sck,
    input  logic            ss_n,
    input  logic            sdi,
    output logic            sdo,
    output logic            sdo_oe,
    input  logic            tx_wr,
    input  logic [BITS-1:0] tx_data,
    input  logic            rx_rd,
    output logic [BITS-1:0] rx_data,
    output logic            rx_valid,
    output logic            byte_done,
    output logic            rx_ovf,
    output logic            wr_col
);

    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] pins_s;
    logic              sck_s, ss_s, sdi_s;
    logic              sel_mode, cfg_ok, go, busy;
    logic              sample_ev, shift_ev, done_ev, tx_bit;
    link_st_t          link_st;

    spi_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_LEN),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({sck, ss_n, sdi}),
        .d_out (pins_s)
    );

    assign sck_s = pins_s[2];
    assign ss_s  = pins_s[1];
    assign sdi_s = pins_s[0];

    assign sel_mode = (mode == MODE_SEL);
    assign cfg_ok   = en && (sel_mode || ((mode == MODE_FREE) && !cke));
    assign go       = cfg_ok && (sel_mode ? !ss_s : 1'b1);
    assign busy     = (link_st == ST_SHIFT);

    spi_link_fsm #(.BITS(BITS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .cpol      (cpol),
        .cke       (cke),
        .smp       (smp),
        .sck_s     (sck_s),
        .state     (link_st),
        .sample_ev (sample_ev),
        .shift_ev  (shift_ev),
        .done_ev   (done_ev)
    );

    spi_byte_path #(.BITS(BITS)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .busy      (busy),
        .sample_ev (sample_ev),
        .shift_ev  (shift_ev),
        .done_ev   (done_ev),
        .sdi_s     (sdi_s),
        .tx_wr     (tx_wr),
        .tx_data   (tx_data),
        .rx_rd     (rx_rd),
        .tx_bit    (tx_bit),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .byte_done (byte_done),
        .rx_ovf    (rx_ovf),
        .wr_col    (wr_col)
    );

    // pad release follows the raw select pin so it is not delayed by the synchronizer
    assign sdo_oe = cfg_ok && !tx_disable && (!sel_mode || !ss_n);
    assign sdo    = sdo_oe ? tx_bit : 1'b0;

    assert_illegal_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |=> (!byte_done && !sdo_oe) || cfg_ok);

    assert_ss_releases_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_mode && ss_n) |-> !sdo_oe);

endmodule

// File: tb/spi_sel_slave_bench.sv
`timescale 1ns/1ps
module spi_sel_slave_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [3:0] mode = 4'b0100;
    logic       cpol = 1'b0, cke = 1'b0, smp = 1'b0, tx_disable = 1'b0;
    logic       sck = 1'b0, ss_n = 1'b1, sdi = 1'b0;
    logic       sdo, sdo_oe;
    logic       tx_wr = 1'b0, rx_rd = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [7:0] rx_data;
    logic       rx_valid, byte_done, rx_ovf, wr_col;

    int checks = 0, fails = 0, cyc = 0, last_chg = 0, done_seen = 0;
    bit running = 1'b0, finished = 1'b0;

    // reference model state
    int         m_st = 0, m_cnt = 0, m_done = 0;
    logic [7:0] m_txbuf = 8'h00, m_txsh = 8'h00, m_rxsh = 8'h00, m_rxbuf = 8'h00;
    bit         m_valid = 0, m_ovf = 0, m_col = 0;
    logic       m_sck = 1'b0;

    always #4 clk = ~clk;

    spi_sel_slave u_spi_sel_slave (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .cpol(cpol), .cke(cke),
        .smp(smp), .tx_disable(tx_disable), .sck(sck), .ss_n(ss_n), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .tx_wr(tx_wr), .tx_data(tx_data),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_valid(rx_valid),
        .byte_done(byte_done), .rx_ovf(rx_ovf), .wr_col(wr_col)
    );

    always @(posedge clk) cyc++;
    always @(negedge clk) if (rst_n && byte_done) done_seen++;

    function automatic bit m_legal();
        return en && (mode == 4'b0100 || (mode == 4'b0101 && !cke));
    endfunction

    function automatic bit m_oe();
        return m_legal() && !tx_disable && (mode != 4'b0100 || !ss_n);
    endfunction

    function automatic void m_eval();
        bit act;
        act = (mode == 4'b0100) ? !ss_n : 1'b1;
        if (!en) begin m_ovf = 0; m_col = 0; end
        if (!(m_legal() && act)) begin
            m_st = 0; m_cnt = 0; m_txsh = m_txbuf;
        end else begin
            if (m_st == 0) m_st = 1;
            if (m_st == 1 && m_sck == cpol) m_st = 2;
        end
    endfunction

    function automatic void m_edge(logic v);
        logic old;
        bit lead, sh, sa;
        int c0;
        old = m_sck;
        m_sck = v;
        if (m_st == 2 && old != v) begin
            lead = (old == cpol);
            sh = cke ? !lead : lead;
            sa = smp ? sh : (cke ? lead : !lead);
            c0 = m_cnt;
            if (sh && c0 > 0) m_txsh = {m_txsh[6:0], 1'b0};
            if (sa) begin
                m_rxsh = {m_rxsh[6:0], sdi};
                if (c0 == 7) begin
                    m_cnt = 0;
                    m_done++;
                    if (m_valid) m_ovf = 1;
                    else begin m_rxbuf = m_rxsh; m_valid = 1; end
                    m_txsh = m_txbuf;
                end else begin
                    m_cnt = c0 + 1;
                end
            end
        end
        m_eval();
    endfunction

    task automatic cmp(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        cmp(tag, act, exp);
    endtask

    // per-clock comparison against the model once inputs have settled
    always @(negedge clk) begin
        if (rst_n && running && (cyc - last_chg >= 6)) begin
            cmp("R7 sdo_oe", int'(sdo_oe), int'(m_oe()));
            if (m_oe()) cmp("R2 sdo", int'(sdo), int'(m_txsh[7]));
            cmp("R3 rx_data", int'(rx_data), int'(m_rxbuf));
            cmp("R13 rx_valid", int'(rx_valid), int'(m_valid));
            cmp("R11 rx_ovf", int'(rx_ovf), int'(m_ovf));
            cmp("R12 wr_col", int'(wr_col), int'(m_col));
            cmp("R3 done count", done_seen, m_done);
        end
    end

    task automatic hold();
        last_chg = cyc;
        repeat (8) @(posedge clk);
        #1;
    endtask

    task automatic cfg(input bit e, input logic [3:0] md, input bit pol, input bit ck, input bit sp);
        en = e; mode = md; cpol = pol; cke = ck; smp = sp;
        m_eval();
        hold();
    endtask

    task automatic set_sck(input logic v);
        sck = v;
        m_edge(v);
        hold();
    endtask

    task automatic sel(input logic v);
        ss_n = v;
        m_eval();
        hold();
    endtask

    task automatic wr(input logic [7:0] d);
        tx_data = d;
        tx_wr = 1'b1;
        if (m_st == 2 && m_cnt > 0) begin
            if (en) m_col = 1;
        end else begin
            m_txbuf = d; m_txsh = d;
        end
        last_chg = cyc;
        @(posedge clk); #1;
        tx_wr = 1'b0;
        hold();
    endtask

    task automatic rd();
        rx_rd = 1'b1;
        m_valid = 0;
        last_chg = cyc;
        @(posedge clk); #1;
        rx_rd = 1'b0;
        hold();
    endtask

    task automatic send_bit(input logic b);
        sdi = b;
        hold();
        set_sck(!cpol);
        set_sck(cpol);
    endtask

    task automatic xfer(input logic [7:0] m);
        for (int i = 7; i >= 0; i--) send_bit(m[i]);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
        summary();
    end

    initial begin
        int d0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        hold();
        running = 1'b1;
        chk("R1 sdo_oe after reset", sdo_oe, 0);
        chk("R1 rx_valid after reset", rx_valid, 0);
        chk("R1 rx_ovf after reset", rx_ovf, 0);
        chk("R1 wr_col after reset", wr_col, 0);
        chk("R1 rx_data after reset", rx_data, 0);

        // select-gated, cpol 0, shift leading, sample trailing
        cfg(1, 4'b0100, 0, 0, 0);
        wr(8'hC3);
        chk("R7 pad released while deselected", sdo_oe, 0);
        sel(0);
        chk("R2 pad driven once selected", sdo_oe, 1);
        chk("R2 msb presented first", sdo, 1);
        xfer(8'hA5);
        chk("R3 received byte", rx_data, 8'hA5);
        chk("R3 valid after byte", rx_valid, 1);
        chk("R3 single completion", done_seen, 1);
        rd();
        chk("R13 read clears valid", rx_valid, 0);

        // cpol 1, trailing-edge shift
        cfg(0, 4'b0100, 1, 1, 0);
        set_sck(1);
        cfg(1, 4'b0100, 1, 1, 0);
        wr(8'h5A);
        xfer(8'h3C);
        chk("R4 cke=1 cpol=1 byte", rx_data, 8'h3C);
        rd();

        // sample moved onto shift edge, both edge choices
        cfg(0, 4'b0100, 0, 0, 1);
        set_sck(0);
        cfg(1, 4'b0100, 0, 0, 1);
        wr(8'h96);
        xfer(8'h69);
        chk("R4 cke=0 smp=1 byte", rx_data, 8'h69);
        rd();
        cfg(0, 4'b0100, 0, 1, 1);
        cfg(1, 4'b0100, 0, 1, 1);
        wr(8'h0F);
        xfer(8'hF0);
        chk("R4 cke=1 smp=1 byte", rx_data, 8'hF0);
        rd();

        // enable while clock sits active
        cfg(0, 4'b0100, 0, 0, 0);
        set_sck(1);
        wr(8'hB1);
        cfg(1, 4'b0100, 0, 0, 0);
        chk("R5 msb held while waiting", sdo, 1);
        d0 = done_seen;
        set_sck(0);
        xfer(8'h42);
        chk("R5 return edge not counted", rx_data, 8'h42);
        chk("R5 exactly one byte", done_seen - d0, 1);
        rd();

        // deselect mid-byte
        wr(8'hE7);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        ss_n = 1'b1;
        @(negedge clk);
        chk("R7 pad released at once", sdo_oe, 0);
        m_eval();
        hold();
        sel(0);
        d0 = done_seen;
        xfer(8'h81);
        chk("R6 byte intact after abort", rx_data, 8'h81);
        chk("R6 one completion after abort", done_seen - d0, 1);
        rd();

        // overflow
        wr(8'h11);
        xfer(8'h22);
        xfer(8'h33);
        chk("R11 overflow raised", rx_ovf, 1);
        chk("R11 older byte kept", rx_data, 8'h22);
        rd();

        // write collision
        wr(8'hD2);
        send_bit(1'b0);
        send_bit(1'b0);
        wr(8'h4B);
        chk("R12 collision flagged", wr_col, 1);
        for (int i = 0; i < 6; i++) send_bit(1'b0);
        chk("R12 buffer unchanged msb", sdo, 1);
        rd();

        // enable low clears count and flags
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        cfg(0, 4'b0100, 0, 0, 0);
        chk("R10 ovf cleared", rx_ovf, 0);
        chk("R10 col cleared", wr_col, 0);
        cfg(1, 4'b0100, 0, 0, 0);
        xfer(8'h5C);
        chk("R10 count restarted", rx_data, 8'h5C);
        rd();

        // receive only
        tx_disable = 1'b1;
        hold();
        chk("R7 tx_disable releases pad", sdo_oe, 0);
        xfer(8'h77);
        chk("R7 receive while output off", rx_data, 8'h77);
        rd();
        tx_disable = 1'b0;
        hold();

        // free-running ignores select
        cfg(0, 4'b0101, 0, 0, 0);
        sel(1);
        cfg(1, 4'b0101, 0, 0, 0);
        chk("R8 pad driven with ss_n high", sdo_oe, 1);
        xfer(8'h3A);
        chk("R8 byte with ss_n high", rx_data, 8'h3A);
        rd();

        // illegal configurations
        cfg(0, 4'b0101, 0, 1, 0);
        cfg(1, 4'b0101, 0, 1, 0);
        chk("R9 free mode with cke=1 idle", sdo_oe, 0);
        d0 = done_seen;
        xfer(8'hFF);
        chk("R9 no byte from illegal cfg", done_seen - d0, 0);
        cfg(1, 4'b0010, 0, 0, 0);
        sel(0);
        chk("R9 unknown mode idle", sdo_oe, 0);
        xfer(8'hFF);
        chk("R9 no byte from unknown mode", done_seen - d0, 0);
        chk("R9 valid untouched", rx_valid, 0);

        summary();
    end

endmodule